// File: doc/BRIEF.md
# Delay Sweep Measurement Controller

This controller measures the propagation delay of an external device with two programmable delay lines and a sampling flip-flop. Each trial sends one launch pulse into both lines together. The reference line is forced to its minimum-delay setting and drives the device under test. The output of the second line clocks a flip-flop that captures the device output, and that captured value returns to the controller as the trial sample.

The controller runs a successive-approximation search over the 10-bit code of the second line. It applies each candidate code and gives it a fixed number of trials. If every trial samples high, the code is too long. If every trial samples low, the code is too short. A mix of high and low marks the matching code. A match ends the search at once. Without a match, the result is the largest code that sampled low, plus one. Codes past either end of the range raise an out-of-range flag.

Top module: `delay_sweep_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is idle: `busy`, `done` and `launch` are 0, `sweep_lock` is 1 and `ref_min_delay` is 0.
- R2: `ref_min_delay` is 1 for every cycle of a measurement, including every cycle in which `launch` is 1, and is 0 when the block is idle.
- R3: Each candidate code is driven on `sweep_code` while `sweep_lock` is 0 for exactly one cycle. The latch takes the code when `sweep_lock` rises. The code then stays unchanged for as long as `sweep_lock` stays 1 in that measurement.
- R4: At least `settle_cycles` clock cycles pass between the latching edge (or the previous accepted sample) and the next launch. `launch` is a one-cycle pulse. No further launch comes until `sample_valid` has returned the trial result.
- R5: Each candidate code gets exactly TRIALS trials (default 8), unless a match ends the search earlier. `sample_bit` = 1 means late (code too long) and 0 means early (code too short). The code is judged late only if all its trials are 1, early only if all are 0, and matched otherwise. A single differing trial is enough for a match.
- R6: The first candidate is 512. Each later candidate sets the next lower bit, from bit 9 down to bit 0, on top of the kept bits. A bit is kept when its code is judged early and dropped when it is judged late. A search without a match therefore uses 10 candidates.
- R7: A matched code ends the search at once and becomes `result`, with `out_of_range` 0.
- R8: When no code matches, `result` is the largest code judged early, plus one.
- R9: If no code is judged early, code 0 is probed last. If code 0 samples late, the result is 0 with `out_of_range` 1. If code 1023 is judged early, the result is 1023 with `out_of_range` 1.
- R10: `done` is a one-cycle pulse that ends the measurement. `busy` is 0 in the following cycle. `result` and `out_of_range` hold until the next measurement finishes.
- R11: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a measurement (taken only when idle) |
| settle_cycles | input | 8 | Minimum wait before each launch; hold stable during a measurement |
| sample_valid | input | 1 | Trial result present on `sample_bit` |
| sample_bit | input | 1 | Flip-flop result: 1 late, 0 early |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Measured code |
| out_of_range | output | 1 | Delay lies outside the sweep range |
| ref_min_delay | output | 1 | Minimum-delay override for the reference line |
| sweep_code | output | 10 | Code for the swept line |
| sweep_lock | output | 1 | 0 = latch transparent, rising edge latches the code |
| launch | output | 1 | Trigger pulse into both delay lines |

## Verification
Two verdicts can land on the same step. A match judged on the tenth and last candidate arrives in the same cycle as the end-of-search result computation, and the match must win over "largest early plus one". The bench provokes this in two ways. One case uses a threshold of 1023 that alternates between trials. The other uses a threshold of 77 where only the first trial of that code samples late, so the mix appears only at bit 0. Both are judged by the exact result value, a cleared out-of-range flag and the total of 80 launches. A second collision is a `start` pulse in the middle of a measurement. It is judged by a single `done` pulse and an unchanged launch count.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  typedef enum logic [1:0] {
    VERD_EARLY = 2'd0,
    VERD_LATE  = 2'd1,
    VERD_MIX   = 2'd2
  } verdict_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SETTLE, ST_FIRE, ST_SAMPLE, ST_DECIDE, ST_DONE
  } state_e;

  // Unanimous-vote rule for one candidate code
  function automatic verdict_e judge(input int unsigned lates, input int unsigned total);
    if (lates == 0)          return VERD_EARLY;
    else if (lates == total) return VERD_LATE;
    else                     return VERD_MIX;
  endfunction

endpackage

// File: rtl/dsm_settle_timer.sv
module dsm_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  // R4
  settle_cap_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= limit));

endmodule

// File: rtl/dsm_vote_counter.sv
module dsm_vote_counter #(
  parameter int TRIALS = 8,
  localparam int TW = $clog2(TRIALS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          take,
  input  logic          bit_in,
  output logic [TW-1:0] lates,
  output logic          last_take
);
  logic [TW-1:0] taken;

  assign last_take = take && (taken == TW'(TRIALS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      taken <= '0;
      lates <= '0;
    end else if (take) begin
      taken <= taken + 1'b1;
      if (bit_in) lates <= lates + 1'b1;
    end
  end

  // R5
  vote_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (taken <= TW'(TRIALS)) && (lates <= taken));

endmodule

// File: rtl/dsm_sar_core.sv
module dsm_sar_core
  import dsm_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          apply,
  input  verdict_e      verdict,
  output logic [CW-1:0] code_o,
  output logic          finish,
  output logic [CW-1:0] res_o,
  output logic          oor_o
);
  localparam logic [CW-1:0] TOP_BIT = CW'(1) << (CW - 1);
  localparam logic [CW-1:0] ALL_ONE = '1;

  logic [CW-1:0] acc, mask, last_early;
  logic          seen_early, probe, any_early;

  assign code_o = probe ? '0 : (acc | mask);

  always_comb begin
    finish     = 1'b0;
    res_o      = code_o;
    oor_o      = 1'b0;
    last_early = (verdict == VERD_EARLY) ? code_o : acc;
    any_early  = seen_early || (verdict == VERD_EARLY);
    if (verdict == VERD_MIX) begin
      finish = 1'b1;
    end else if (probe) begin
      finish = 1'b1;
      if (verdict == VERD_EARLY) res_o = CW'(1);
      else begin
        res_o = '0;
        oor_o = 1'b1;
      end
    end else if (mask[0] && any_early) begin
      finish = 1'b1;
      if (last_early == ALL_ONE) begin
        res_o = ALL_ONE;
        oor_o = 1'b1;
      end else begin
        res_o = last_early + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      acc        <= '0;
      mask       <= TOP_BIT;
      seen_early <= 1'b0;
      probe      <= 1'b0;
    end else if (apply && !finish) begin
      if (verdict == VERD_EARLY) begin
        acc        <= code_o;
        seen_early <= 1'b1;
      end
      if (mask[0]) probe <= 1'b1;
      else         mask  <= mask >> 1;
    end
  end

  // R6
  mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(mask) == 1);

endmodule

// File: rtl/delay_sweep_ctrl.sv
module delay_sweep_ctrl
  import dsm_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int TRIALS   = 8,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                sample_valid,
  input  logic                sample_bit,
  output logic                busy,
  output logic                done,
  output logic [CODE_W-1:0]   result,
  output logic                out_of_range,
  output logic                ref_min_delay,
  output logic [CODE_W-1:0]   sweep_code,
  output logic                sweep_lock,
  output logic                launch
);
  localparam int TW = $clog2(TRIALS + 1);

  state_e state, state_nx;

  logic              settle_expired, take, last_take, finish, oor_nx, init;
  logic [TW-1:0]     lates;
  logic [CODE_W-1:0] res_nx;
  verdict_e          verdict;

  assign busy          = (state != ST_IDLE);
  assign done          = (state == ST_DONE);
  assign launch        = (state == ST_FIRE);
  assign sweep_lock    = (state != ST_LOAD);
  assign ref_min_delay = busy;
  assign take          = (state == ST_SAMPLE) && sample_valid;
  assign init          = (state == ST_IDLE) && start;
  assign verdict       = judge(int'(lates), TRIALS);

  dsm_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk(clk), .rst(rst), .run(state == ST_SETTLE),
    .limit(settle_cycles), .expired(settle_expired)
  );

  dsm_vote_counter #(.TRIALS(TRIALS)) u_vote (
    .clk(clk), .rst(rst), .clear(state == ST_LOAD), .take(take),
    .bit_in(sample_bit), .lates(lates), .last_take(last_take)
  );

  dsm_sar_core #(.CW(CODE_W)) u_sar (
    .clk(clk), .rst(rst), .init(init), .apply(state == ST_DECIDE),
    .verdict(verdict), .code_o(sweep_code), .finish(finish),
    .res_o(res_nx), .oor_o(oor_nx)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (start) state_nx = ST_LOAD;
      ST_LOAD:   state_nx = ST_SETTLE;
      ST_SETTLE: if (settle_expired) state_nx = ST_FIRE;
      ST_FIRE:   state_nx = ST_SAMPLE;
      ST_SAMPLE: if (take) state_nx = last_take ? ST_DECIDE : ST_SETTLE;
      ST_DECIDE: state_nx = finish ? ST_DONE : ST_LOAD;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      result       <= '0;
      out_of_range <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_DECIDE && finish) begin
        result       <= res_nx;
        out_of_range <= oor_nx;
      end
    end
  end

  // R2
  fire_refmin_chk: assert property (@(posedge clk) disable iff (rst)
    launch |-> (ref_min_delay && sweep_lock));

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sweep_lock && $past(sweep_lock) && busy) |-> $stable(sweep_code));

  // R4
  launch_single_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R9
  oor_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (done && out_of_range) |-> (result == '0 || result == '1));

endmodule

// File: tb/tb_delay_sweep_ctrl.sv
module tb_delay_sweep_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] settle_in = 8'd2;
  logic       sample_valid = 1'b0;
  logic       sample_bit = 1'b0;
  logic       busy, done, out_of_range, ref_min_delay, sweep_lock, launch;
  logic [9:0] result, sweep_code;

  int checks = 0, fails = 0;
  int thr = 0, mode = 0, lat = 1;
  int fires = 0, done_cnt = 0, mon_err = 0, first_code = -1;
  int latched = 0, trial_no = 0, gap = 0, pend = 0, low_run = 0;
  bit prev_lock = 1'b1, prev_done = 1'b0;

  always #5 clk = ~clk;

  delay_sweep_ctrl dut (
    .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_in),
    .sample_valid(sample_valid), .sample_bit(sample_bit), .busy(busy),
    .done(done), .result(result), .out_of_range(out_of_range),
    .ref_min_delay(ref_min_delay), .sweep_code(sweep_code),
    .sweep_lock(sweep_lock), .launch(launch)
  );

  // mode 0: late when code >= thr; 1: alternate at thr; 2: only trial 0 late at thr
  function automatic bit model(int c, int tr);
    if (mode == 0) return c >= thr;
    if (c > thr) return 1'b1;
    if (c < thr) return 1'b0;
    if (mode == 1) return tr[0];
    return tr == 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // delay-line, device and sampler model plus protocol monitor
  always @(negedge clk) begin
    if (rst) begin
      prev_lock = 1'b1; pend = 0; sample_valid = 1'b0; prev_done = 1'b0;
    end else begin
      bit was_valid;
      was_valid = sample_valid;
      if (sweep_lock && !prev_lock) begin
        latched = sweep_code; trial_no = 0; gap = 0;
        if (first_code < 0) first_code = sweep_code;
      end else if (was_valid) gap = 0;
      else gap++;
      if (!sweep_lock) begin
        low_run++;
        if (low_run > 1) mon_err++;             // R3 one-cycle load
      end else low_run = 0;
      if (sweep_lock && busy && sweep_code != latched && prev_lock) mon_err++; // R3
      if (!busy && ref_min_delay) mon_err++;     // R2
      sample_valid = 1'b0;
      if (launch) begin
        fires++;
        if (!ref_min_delay) mon_err++;           // R2
        if (gap < int'(settle_in)) mon_err++;    // R4
        if (pend != 0) mon_err++;                // R4 launch before sample
        pend = lat;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          sample_bit = model(latched, trial_no);
          sample_valid = 1'b1;
          trial_no++;
        end
      end
      if (done) done_cnt++;
      if (prev_done && busy) mon_err++;          // R10
      prev_done = done;
      prev_lock = sweep_lock;
    end
  end

  task automatic run_case(input int t, input int md, input int st, input int latency,
                          input int exp_res, input bit exp_oor, input int exp_fires,
                          input string req, input bit poke);
    thr = t; mode = md; settle_in = 8'(st); lat = latency;
    fires = 0; done_cnt = 0; mon_err = 0; first_code = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1;                              // R11 start while busy
      @(negedge clk) start = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(result == 10'(exp_res), {req, " result"}, result, exp_res);
    check(out_of_range == exp_oor, {req, " out_of_range"}, out_of_range, exp_oor);
    check(fires == exp_fires, {req, " R5 launch count"}, fires, exp_fires);
    check(first_code == 512, {req, " R6 first code"}, first_code, 512);
    check(mon_err == 0, {req, " R2/R3/R4/R10 protocol"}, mon_err, 0);
    check(done_cnt == 1 && !busy, {req, " R10 single done"}, done_cnt, 1);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check(!busy && !done && !launch && sweep_lock && !ref_min_delay,
          "R1 reset outputs", {busy, done, launch, sweep_lock, ref_min_delay}, 5'b00010);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !launch && sweep_lock && !ref_min_delay,
          "R1 idle after reset", {busy, launch, sweep_lock, ref_min_delay}, 4'b0010);
  endtask

  task automatic test_hold();
    int keep;
    keep = result;
    settle_in = 8'd9;
    repeat (20) @(negedge clk);
    check(result == 10'(keep) && !busy && done_cnt == 1, "R10 result holds", result, keep);
  endtask

  initial begin
    test_reset();
    run_case(300,  0, 2, 1, 300,  1'b0, 80, "R8 step 300", 1'b0);
    run_case(512,  1, 0, 2, 512,  1'b0, 8,  "R7 match 512", 1'b0);
    run_case(77,   2, 5, 1, 77,   1'b0, 80, "R5 single-late match 77", 1'b0);
    run_case(1023, 1, 1, 1, 1023, 1'b0, 80, "R7 final-step match 1023", 1'b0);
    run_case(0,    0, 3, 2, 0,    1'b1, 88, "R9 code 0 late", 1'b0);
    run_case(1024, 0, 0, 1, 1023, 1'b1, 80, "R9 code 1023 early", 1'b0);
    run_case(0,    1, 2, 1, 0,    1'b0, 88, "R9 probe match 0", 1'b0);
    run_case(1,    0, 1, 1, 1,    1'b0, 88, "R9 probe early", 1'b0);
    run_case(300,  0, 4, 2, 300,  1'b0, 80, "R11 start while busy", 1'b1);
    test_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule